// File: doc/BRIEF.md
# LSSD Non-Overlapping Clock Sequencer

This block drives the three level-sensitive clocks of a shift-register-latch chain from one fast reference clock: a system clock `clk_c` and two shift clocks `clk_a` and `clk_b`. In normal mode it repeats `clk_c` pulses while both shift clocks rest low. In shift mode it holds `clk_c` low. On request it performs a counted number of shift steps, and each step is an `clk_a` pulse followed by a `clk_b` pulse.

Pulse width and dead time are set at run time in reference cycles. Each is sampled when a phase begins, and a zero value is treated as one. Any falling clock edge is followed by at least one cycle in which all three clocks are low. A mode request is taken only in the idle state, where every clock is low. Dropping the run enable shuts all clocks off on the next reference edge.

Top module: `lssd_clk_seq`

## Requirements
- R1: With `shift_mode` = 0 and `run_en` = 1, `clk_a` and `clk_b` stay 0. `clk_c` repeats a high phase of Wp cycles followed by Wd+1 cycles low. Wp is `pulse_w` and Wd is `dead_w`, each read as 1 when 0.
- R2: With `shift_mode` = 1, `clk_c` stays 0. A `shift_start` taken in idle with `shift_steps` = N > 0 produces exactly N `clk_a` pulses and N `clk_b` pulses, strictly alternating and starting with `clk_a`. It then produces exactly one `shift_done` pulse.
- R3: No two of `clk_a`, `clk_b` and `clk_c` are ever high in the same cycle.
- R4: Every clock pulse of a sequence that is not aborted is high for exactly Wp consecutive cycles.
- R5: If `run_en` is 0 at a clock edge, all three clocks are 0 in the following cycle. A shift sequence that is cut off this way never raises `shift_done`.
- R6: Within a shift sequence, each fall of `clk_a` or `clk_b` is followed by exactly Wd all-low cycles before the next rise.
- R7: `shift_done` is high for one cycle. For N > 0 it is the (Wd+1)-th cycle after the last `clk_b` high cycle. For N = 0 it is the cycle after `shift_start` is taken, with no pulse issued.
- R8: `shift_mode` (0 = normal, 1 = shift) changes only when all clocks have been low for the previous cycle. A request made while `clk_c` is high leaves that pulse at its full width and takes effect afterwards.
- R9: `shift_start` is ignored in normal mode and while a shift sequence is in progress.
- R10: After reset all clocks, `shift_done` and `shift_mode` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Master enable; 0 turns every latch clock off |
| mode_req | input | 1 | Requested mode: 0 normal, 1 shift |
| shift_start | input | 1 | Starts a shift sequence (shift mode, idle only) |
| shift_steps | input | STEP_W | Number of A/B steps in the sequence |
| pulse_w | input | PW_W | High width of each clock pulse, in cycles |
| dead_w | input | DW_W | All-low guard after each fall, in cycles |
| clk_c | output | 1 | System latch clock |
| clk_a | output | 1 | First shift clock |
| clk_b | output | 1 | Second shift clock |
| shift_mode | output | 1 | Mode currently in force |
| shift_done | output | 1 | One-cycle pulse when a shift sequence completes |

## Verification
Two events can land on the same cycle: a mode request can arrive while `clk_c` is high, and a shift sequence can be cut off by `run_en` falling. The bench raises `mode_req` in the first cycle of a `clk_c` pulse. It then judges that the pulse keeps its full width and that `shift_mode` holds until the clocks are low. It also drops `run_en` in the middle of a shift sequence that has a fresh start request pending. There it expects the clocks to be off on the next cycle and no `shift_done` to follow.

// File: rtl/lssd_clk_pkg.sv
package lssd_clk_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_C_HI,
      ST_A_HI,
      ST_B_HI,
      ST_GAP
   } seq_state_e;

   typedef enum logic [1:0] {
      GK_AFTER_C,
      GK_AFTER_A,
      GK_AFTER_B,
      GK_ABORT
   } gap_kind_e;

endpackage

// File: rtl/lssd_dwell_timer.sv
module lssd_dwell_timer #(
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] len,
   output logic             last
);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q <= ONE;
         cnt_q <= '0;
      end else if (load) begin
         len_q <= (len == '0) ? ONE : len;
         cnt_q <= '0;
      end else if (!last) begin
         cnt_q <= cnt_q + ONE;
      end
   end

   assign last = (cnt_q == (len_q - ONE));

endmodule

// File: rtl/lssd_step_counter.sv
module lssd_step_counter #(
   parameter int STEP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [STEP_W-1:0] count,
   input  logic              dec,
   output logic              last,
   output logic              req_zero
);
   localparam logic [STEP_W-1:0] ONE = STEP_W'(1);

   logic [STEP_W-1:0] rem_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    rem_q <= '0;
      else if (load) rem_q <= count;
      else if (dec)  rem_q <= rem_q - ONE;
   end

   assign last     = (rem_q == ONE);
   assign req_zero = (count == '0);

endmodule

// File: rtl/lssd_clk_seq.sv
module lssd_clk_seq
   import lssd_clk_pkg::*;
#(
   parameter int STEP_W = 8,
   parameter int PW_W   = 4,
   parameter int DW_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              mode_req,
   input  logic              shift_start,
   input  logic [STEP_W-1:0] shift_steps,
   input  logic [PW_W-1:0]   pulse_w,
   input  logic [DW_W-1:0]   dead_w,
   output logic              clk_c,
   output logic              clk_a,
   output logic              clk_b,
   output logic              shift_mode,
   output logic              shift_done
);
   localparam int LEN_W = (PW_W > DW_W) ? PW_W : DW_W;

   generate
      if (PW_W < 1 || PW_W > 16) begin : g_bad_pw
         $error("lssd_clk_seq: PW_W out of range");
      end
      if (DW_W < 1 || DW_W > 16) begin : g_bad_dw
         $error("lssd_clk_seq: DW_W out of range");
      end
      if (STEP_W < 1) begin : g_bad_step
         $error("lssd_clk_seq: STEP_W must be positive");
      end
   endgenerate

   seq_state_e state_q, state_d;
   gap_kind_e  gap_q, gap_d, gap_eff;
   logic       mode_q, mode_d;
   logic       done_d;
   logic       tmr_load, tmr_last;
   logic       use_dead;
   logic [LEN_W-1:0] tmr_len;
   logic       step_load, step_dec, step_last, step_zero;

   assign tmr_len = use_dead ? LEN_W'(dead_w) : LEN_W'(pulse_w);
   assign gap_eff = run_en ? gap_q : GK_ABORT;

   lssd_dwell_timer #(.LEN_W(LEN_W)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .load (tmr_load),
      .len  (tmr_len),
      .last (tmr_last)
   );

   lssd_step_counter #(.STEP_W(STEP_W)) u_steps (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (step_load),
      .count   (shift_steps),
      .dec     (step_dec),
      .last    (step_last),
      .req_zero(step_zero)
   );

   always_comb begin
      state_d   = state_q;
      gap_d     = gap_q;
      mode_d    = mode_q;
      done_d    = 1'b0;
      tmr_load  = 1'b0;
      use_dead  = 1'b0;
      step_load = 1'b0;
      step_dec  = 1'b0;
      case (state_q)
         ST_IDLE: begin
            mode_d = mode_req;
            if (run_en) begin
               if (!mode_req) begin
                  state_d  = ST_C_HI;
                  tmr_load = 1'b1;
               end else if (shift_start) begin
                  if (step_zero) begin
                     done_d = 1'b1;
                  end else begin
                     step_load = 1'b1;
                     state_d   = ST_A_HI;
                     tmr_load  = 1'b1;
                  end
               end
            end
         end
         ST_C_HI, ST_A_HI, ST_B_HI: begin
            if (!run_en || tmr_last) begin
               state_d  = ST_GAP;
               tmr_load = 1'b1;
               use_dead = 1'b1;
               if (!run_en)                gap_d = GK_ABORT;
               else if (state_q == ST_C_HI) gap_d = GK_AFTER_C;
               else if (state_q == ST_A_HI) gap_d = GK_AFTER_A;
               else                         gap_d = GK_AFTER_B;
            end
         end
         ST_GAP: begin
            gap_d = gap_eff;
            if (tmr_last) begin
               case (gap_eff)
                  GK_AFTER_A: begin
                     state_d  = ST_B_HI;
                     tmr_load = 1'b1;
                  end
                  GK_AFTER_B: begin
                     if (step_last) begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                     end else begin
                        state_d  = ST_A_HI;
                        tmr_load = 1'b1;
                        step_dec = 1'b1;
                     end
                  end
                  default: state_d = ST_IDLE;
               endcase
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         gap_q      <= GK_ABORT;
         mode_q     <= 1'b0;
         shift_done <= 1'b0;
         clk_c      <= 1'b0;
         clk_a      <= 1'b0;
         clk_b      <= 1'b0;
      end else begin
         state_q    <= state_d;
         gap_q      <= gap_d;
         mode_q     <= mode_d;
         shift_done <= done_d;
         clk_c      <= (state_d == ST_C_HI);
         clk_a      <= (state_d == ST_A_HI);
         clk_b      <= (state_d == ST_B_HI);
      end
   end

   assign shift_mode = mode_q;

endmodule

// File: rtl/lssd_clk_seq_chk.sv
module lssd_clk_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic run_en,
   input logic clk_c,
   input logic clk_a,
   input logic clk_b,
   input logic shift_mode,
   input logic shift_done
);
   // R3
   ab_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(clk_a && clk_b));
   // R3
   cb_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(clk_c && clk_b));
   // R3
   ca_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(clk_c && clk_a));
   // R5
   run_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (!clk_a && !clk_b && !clk_c));
   // R6
   a_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_a) |-> (!clk_b && !clk_c));
   // R6
   b_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_b) |-> (!clk_a && !clk_c));
   // R6
   c_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_c) |-> (!clk_a && !clk_b));
   // R1
   normal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_mode |-> (!clk_a && !clk_b));
   // R2
   shift_c_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_mode |-> !clk_c);
   // R8
   mode_calm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(shift_mode) |-> $past(!clk_a && !clk_b && !clk_c));
   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_done |=> !shift_done);
   // R7
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_done |-> (!clk_a && !clk_b && !clk_c));
endmodule

bind lssd_clk_seq lssd_clk_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run_en    (run_en),
   .clk_c     (clk_c),
   .clk_a     (clk_a),
   .clk_b     (clk_b),
   .shift_mode(shift_mode),
   .shift_done(shift_done)
);

// File: tb/lssd_clk_seq_bench.sv
`timescale 1ns/1ps
module lssd_clk_seq_bench;
   localparam int STEP_W = 8;
   localparam int PW_W   = 4;
   localparam int DW_W   = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run_en = 1'b0;
   logic mode_req = 1'b0;
   logic shift_start = 1'b0;
   logic [STEP_W-1:0] shift_steps = '0;
   logic [PW_W-1:0]   pulse_w = 4'd2;
   logic [DW_W-1:0]   dead_w = 4'd1;
   logic clk_c, clk_a, clk_b, shift_mode, shift_done;

   always #5 clk = ~clk;

   lssd_clk_seq #(.STEP_W(STEP_W), .PW_W(PW_W), .DW_W(DW_W)) u_lssd_clk_seq (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode_req(mode_req),
      .shift_start(shift_start), .shift_steps(shift_steps),
      .pulse_w(pulse_w), .dead_w(dead_w),
      .clk_c(clk_c), .clk_a(clk_a), .clk_b(clk_b),
      .shift_mode(shift_mode), .shift_done(shift_done)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int eff(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   // monitor state
   bit mon_on = 0;
   bit width_chk = 1;
   bit gap_chk = 0;
   bit seen_fall = 0;
   int exp_pw = 1;
   int exp_gap = 1;
   int hi_len = 0;
   int low_len = 0;
   int a_rises = 0, b_rises = 0, c_rises = 0, done_cnt = 0;
   int last_rise = 0; // 0 none, 1 A, 2 B, 3 C
   logic pa = 0, pb = 0, pc = 0;

   always @(negedge clk) begin
      if (mon_on) begin
         automatic bit any_now = clk_a | clk_b | clk_c;
         automatic bit any_prev = pa | pb | pc;
         automatic bit ra = clk_a & ~pa;
         automatic bit rb = clk_b & ~pb;
         automatic bit rc = clk_c & ~pc;
         if (ra | rb | rc) begin
            if (gap_chk && seen_fall)
               chk(low_len == exp_gap, "R6 gap before rise", low_len, exp_gap);
            if (rb) chk(last_rise == 1, "R2 B follows A", last_rise, 1);
            if (ra) chk(last_rise != 1, "R2 A follows B", last_rise, 2);
            if (rc) chk(shift_mode == 1'b0, "R1 C only in normal", shift_mode, 0);
            if (ra) begin a_rises++; last_rise = 1; end
            if (rb) begin b_rises++; last_rise = 2; end
            if (rc) begin c_rises++; last_rise = 3; end
            hi_len = 1;
         end else if (any_now) begin
            hi_len++;
         end
         if (!any_now && any_prev) begin
            if (width_chk) chk(hi_len == exp_pw, "R4 pulse width", hi_len, exp_pw);
            seen_fall = 1;
            low_len = 1;
         end else if (!any_now) begin
            low_len++;
         end else begin
            low_len = 0;
         end
         if (shift_done) begin
            done_cnt++;
            if (gap_chk && seen_fall)
               chk(low_len == exp_gap + 1, "R7 done timing", low_len, exp_gap + 1);
         end
         pa = clk_a; pb = clk_b; pc = clk_c;
      end
   end

   task automatic step(input int n = 1);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic wait_mode(input logic m);
      for (int i = 0; i < 60; i++) begin
         if (shift_mode == m) break;
         step();
      end
      chk(shift_mode == m, "R8 mode reached", shift_mode, m);
   endtask

   task automatic set_times(input int p, input int d);
      pulse_w = PW_W'(p);
      dead_w  = DW_W'(d);
      exp_pw  = eff(p);
   endtask

   // runs one shift sequence from shift idle and checks the counts
   task automatic do_shift(input int n, input bit extra_start);
      int a0, b0, d0;
      a0 = a_rises; b0 = b_rises; d0 = done_cnt;
      exp_gap = eff(int'(dead_w));
      seen_fall = 0; last_rise = 0; gap_chk = 1;
      shift_steps = STEP_W'(n);
      shift_start = 1'b1;
      step();
      shift_start = 1'b0;
      if (extra_start) begin
         step(3);
         shift_steps = STEP_W'(n + 4);
         shift_start = 1'b1;
         step();
         shift_start = 1'b0;
      end
      for (int i = 0; i < 3000; i++) begin
         if (done_cnt != d0) break;
         step();
      end
      step(4);
      chk(a_rises - a0 == n, "R2 A pulse count", a_rises - a0, n);
      chk(b_rises - b0 == n, "R2 B pulse count", b_rises - b0, n);
      chk(done_cnt - d0 == 1, extra_start ? "R9 busy start ignored" : "R2 one done",
          done_cnt - d0, 1);
      gap_chk = 0;
   endtask

   task automatic run_normal(input int cycles);
      int c0;
      mode_req = 1'b0;
      wait_mode(1'b0);
      c0 = c_rises;
      exp_gap = eff(int'(dead_w)) + 1;
      seen_fall = 0;
      gap_chk = 1;
      step(cycles);
      gap_chk = 0;
      chk(c_rises > c0, "R1 C pulses present", c_rises - c0, 1);
   endtask

   initial begin
      int c_keep, d_keep, a_keep;
      void'($urandom(32'd4242));
      step(3);
      rst_n = 1'b1;
      step();
      // R10 reset state
      chk({clk_a, clk_b, clk_c} == 3'b000, "R10 clocks off after reset", {clk_a, clk_b, clk_c}, 0);
      chk(shift_done == 1'b0, "R10 done low", shift_done, 0);
      chk(shift_mode == 1'b0, "R10 mode normal", shift_mode, 0);
      pa = clk_a; pb = clk_b; pc = clk_c;
      mon_on = 1;

      // directed normal run, zero width read as one
      set_times(0, 0);
      run_en = 1'b1;
      run_normal(40);

      // R9 start ignored in normal mode
      a_keep = a_rises;
      d_keep = done_cnt;
      shift_steps = 8'd3;
      for (int i = 0; i < 5; i++) begin
         shift_start = 1'b1; step(); shift_start = 1'b0; step(3);
      end
      chk(a_rises == a_keep && b_rises == 0, "R9 start ignored in normal", a_rises - a_keep, 0);
      chk(done_cnt == d_keep, "R9 no done in normal", done_cnt - d_keep, 0);

      // R8 mode request while C is high
      mode_req = 1'b1;
      mode_req = 1'b0;
      set_times(0, 0);
      mode_req = 1'b1;
      mode_req = 1'b0;
      // move to shift, set width 4, return to normal
      mode_req = 1'b1; wait_mode(1'b1);
      set_times(4, 2);
      run_normal(30);
      for (int i = 0; i < 40; i++) begin
         if (clk_c && !pc) break;
         step();
      end
      // pc was just copied by monitor; detect a fresh rise instead
      for (int i = 0; i < 40; i++) begin
         if (!clk_c) break;
         step();
      end
      for (int i = 0; i < 40; i++) begin
         if (clk_c) break;
         step();
      end
      c_keep = c_rises;
      mode_req = 1'b1;
      for (int i = 0; i < 3; i++) begin
         chk(shift_mode == 1'b0, "R8 mode held while C high", shift_mode, 0);
         step();
      end
      step(20);
      chk(shift_mode == 1'b1, "R8 mode taken after pulse", shift_mode, 1);
      chk(c_rises == c_keep, "R8 no C after switch", c_rises - c_keep, 0);

      // R7 zero-step request
      d_keep = done_cnt;
      shift_steps = '0;
      shift_start = 1'b1;
      step();
      shift_start = 1'b0;
      chk(shift_done == 1'b1, "R7 zero steps done next cycle", shift_done, 1);
      step();
      chk(shift_done == 1'b0, "R7 done one cycle", shift_done, 0);
      chk(a_rises == a_keep, "R7 zero steps no pulse", a_rises - a_keep, 0);

      // directed shift sequences
      set_times(1, 1);
      do_shift(1, 0);
      set_times(3, 0);
      do_shift(5, 0);
      set_times(2, 3);
      do_shift(3, 1);

      // R5 abort mid sequence
      set_times(2, 1);
      d_keep = done_cnt;
      shift_steps = 8'd6;
      shift_start = 1'b1; step(); shift_start = 1'b0;
      for (int i = 0; i < 40; i++) begin
         if (clk_b) break;
         step();
      end
      width_chk = 0;
      run_en = 1'b0;
      shift_start = 1'b1;
      step();
      chk({clk_a, clk_b, clk_c} == 3'b000, "R5 clocks off after run_en low",
          {clk_a, clk_b, clk_c}, 0);
      step(30);
      shift_start = 1'b0;
      chk(done_cnt == d_keep, "R5 no done after abort", done_cnt - d_keep, 0);
      a_keep = a_rises;
      run_en = 1'b1;
      step(20);
      chk(a_rises == a_keep, "R5 no resume without start", a_rises - a_keep, 0);
      width_chk = 1;

      // constrained random mix
      for (int it = 0; it < 8; it++) begin
         int p, d, n;
         p = $urandom % 5;
         d = $urandom % 4;
         n = 1 + ($urandom % 6);
         mode_req = 1'b1; wait_mode(1'b1);
         set_times(p, d);
         if (($urandom % 2) == 0) run_normal(20 + ($urandom % 20));
         mode_req = 1'b1; wait_mode(1'b1);
         do_shift(n, ($urandom % 3) == 0);
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule